// File: doc/BRIEF.md
# Page Register Column Access Unit

This block is the device-side page data register of a NAND-style memory, together with the column pointer that walks through it. A command decoder in front of it loads a start column in two byte-wide address cycles. After that, each read strobe returns the byte under the pointer, and each write strobe stores a byte there. Either strobe then moves the pointer one column forward. The host can move the pointer as often as it likes inside the open page, both while streaming data out and while loading program data, without a new transfer from the array.

The page width is set by the sector parameters. Each sector pairs a main field with a spare field. All main fields come first in the column space, and all spare fields follow them. With 512 main bytes and 16 spare bytes per sector and eight sectors, the page is 4224 bytes. The default parameters build a smaller page so that elaboration stays light: 64 main bytes and 2 spare bytes per sector, eight sectors, 528 bytes in all. Columns at or above the page width belong to hidden parity storage, and the host can never reach them.

The block also polices program loads. It counts program confirms against a limit of four per page, and it checks that every load covered the main field and the spare field of each sector it touched.

Top module: `pr_page_reg`

## Requirements
- R1: After reset, col_o is 0, dout_o is 0x00, and col_err_o, sec_err_o and npp_err_o are all 0.
- R2: A column load takes two col_ld_i cycles. The first carries the low byte on din_i and the second carries the high byte. The new column appears on col_o in the cycle after the second load cycle.
- R3: When busy_i is low, a read strobe puts the byte stored at the current column on dout_o in the next cycle and advances col_o by one.
- R4: When busy_i is low, a write strobe stores din_i at the current column and advances col_o by one.
- R5: The column may be reloaded any number of times within the open page. Bytes already written stay readable after each reload.
- R6: A loaded column at or above the page width (528 with the default parameters) is clamped to the last valid column and sets col_err_o. The next in-range load clears col_err_o.
- R7: The pointer saturates at the last valid column and never wraps. Further reads at that column return the same byte, and col_o stays at the last column.
- R8: While busy_i is high, read and write strobes have no effect: col_o and dout_o hold and no byte is stored.
- R9: Up to four pgm_cfm_i pulses are accepted per page. The fifth sets npp_err_o, which stays set until page_open_i.
- R10: Main field k covers columns k*64 to k*64+63. Spare field k covers columns 512+2k and 513+2k. On pgm_cfm_i, if any sector had writes in only one of its two fields since the previous confirm, sec_err_o is set and stays set until page_open_i.
- R11: page_open_i sets col_o to 0, clears the confirm count, sec_err_o, npp_err_o and the per-sector write tracking, and leaves the stored bytes in place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busy_i | input | 1 | Array operation in progress; data strobes are ignored while high |
| rd_i | input | 1 | Read strobe, one cycle per byte |
| wr_i | input | 1 | Write strobe, one cycle per byte |
| col_ld_i | input | 1 | Column address cycle from the command decoder |
| pgm_cfm_i | input | 1 | Program confirm for the current load |
| page_open_i | input | 1 | A new page is opened |
| din_i | input | 8 | Write data, or a column address byte |
| dout_o | output | 8 | Read data |
| col_o | output | CW ($clog2(PAGE+1)) | Current column |
| col_err_o | output | 1 | The last column load was out of range and was clamped |
| sec_err_o | output | 1 | A program load covered only one field of some sector |
| npp_err_o | output | 1 | Too many program confirms on this page |

## Verification
The assertions take for granted that the command decoder never raises a column load cycle, a strobe, a confirm or a page open in the same cycle as one of the others, and that the two address cycles of a load are not split by a strobe. The tests drive one control pulse per cycle from a task at the falling clock edge, and they always issue address cycles as a back-to-back pair. Busy windows are raised between strobes, so they never cut into an address load.

// File: rtl/pr_pkg.sv
package pr_pkg;

    typedef logic [7:0] byte_t;

    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } col_phase_e;

    typedef struct packed {
        logic rd;
        logic wr;
    } strobe_t;

    function automatic logic [15:0] join_col(input byte_t hi, input byte_t lo);
        return {hi, lo};
    endfunction

endpackage

// File: rtl/pr_col_ctr.sv
module pr_col_ctr
    import pr_pkg::*;
#(
    parameter int PAGE = 528,
    parameter int CW   = $clog2(PAGE + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          page_open,
    input  logic          col_ld,
    input  byte_t         din,
    input  logic          adv,
    output logic [CW-1:0] col,
    output logic          col_err
);
    localparam logic [CW-1:0] LAST = CW'(PAGE - 1);

    col_phase_e    phase_q;
    byte_t         lo_q;
    logic [CW-1:0] col_q;
    logic          err_q;
    logic [15:0]   full;

    assign full = join_col(din, lo_q);

    always_ff @(posedge clk) begin
        if (rst || page_open) begin
            phase_q <= PH_LOW;
            lo_q    <= '0;
            col_q   <= '0;
            if (rst) err_q <= 1'b0;
        end else if (col_ld) begin
            if (phase_q == PH_LOW) begin
                lo_q    <= din;
                phase_q <= PH_HIGH;
            end else begin
                phase_q <= PH_LOW;
                if (full >= 16'(PAGE)) begin
                    col_q <= LAST;
                    err_q <= 1'b1;
                end else begin
                    col_q <= full[CW-1:0];
                    err_q <= 1'b0;
                end
            end
        end else if (adv && col_q != LAST) begin
            col_q <= col_q + 1'b1;
        end
    end

    assign col     = col_q;
    assign col_err = err_q;

    AST_COL_IN_PAGE: assert property (@(posedge clk) disable iff (rst)
        col_q <= LAST);                                               // R6
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        adv && !col_ld && !page_open && col_q != LAST |=> col_q == $past(col_q) + 1'b1); // R3
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        adv && !col_ld && !page_open && col_q == LAST |=> col_q == LAST); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        !adv && !col_ld && !page_open |=> $stable(col_q));            // R8

endmodule

// File: rtl/pr_store.sv
module pr_store
    import pr_pkg::*;
#(
    parameter int PAGE = 528,
    parameter int CW   = $clog2(PAGE + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  strobe_t       stb,
    input  logic [CW-1:0] col,
    input  byte_t         din,
    output byte_t         dout
);
    byte_t mem [PAGE];
    byte_t dout_q;

    always_ff @(posedge clk) begin
        if (stb.wr) mem[col] <= din;
    end

    always_ff @(posedge clk) begin
        if (rst)         dout_q <= '0;
        else if (stb.rd) dout_q <= mem[col];
    end

    assign dout = dout_q;

    AST_DOUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !stb.rd |=> $stable(dout_q));                                 // R8

endmodule

// File: rtl/pr_pgm_track.sv
module pr_pgm_track #(
    parameter int SEC_MAIN  = 64,
    parameter int SEC_SPARE = 2,
    parameter int NSEC      = 8,
    parameter int MAX_LOADS = 4,
    parameter int CW        = 10
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          page_open,
    input  logic          we,
    input  logic [CW-1:0] col,
    input  logic          cfm,
    output logic          sec_err,
    output logic          npp_err
);
    localparam int MAIN_TOTAL = SEC_MAIN * NSEC;
    localparam int SW = (NSEC > 1) ? $clog2(NSEC) : 1;
    localparam int NW = $clog2(MAX_LOADS + 1);

    logic [NSEC-1:0] main_t;
    logic [NSEC-1:0] spare_t;
    logic            in_main;
    logic [SW-1:0]   sec_idx;
    logic [NW-1:0]   cnt_q;
    logic            sec_q;
    logic            npp_q;
    logic            unpaired;

    always_comb begin
        in_main = int'(col) < MAIN_TOTAL;
        if (in_main) sec_idx = SW'(int'(col) / SEC_MAIN);
        else         sec_idx = SW'((int'(col) - MAIN_TOTAL) / SEC_SPARE);
    end

    for (genvar s = 0; s < NSEC; s++) begin : g_sec
        always_ff @(posedge clk) begin
            if (rst || page_open || cfm) begin
                main_t[s]  <= 1'b0;
                spare_t[s] <= 1'b0;
            end else if (we && sec_idx == SW'(s)) begin
                if (in_main) main_t[s]  <= 1'b1;
                else         spare_t[s] <= 1'b1;
            end
        end
    end

    assign unpaired = |(main_t ^ spare_t);

    always_ff @(posedge clk) begin
        if (rst || page_open) begin
            cnt_q <= '0;
            sec_q <= 1'b0;
            npp_q <= 1'b0;
        end else if (cfm) begin
            if (unpaired) sec_q <= 1'b1;
            if (cnt_q == NW'(MAX_LOADS)) npp_q <= 1'b1;
            else                         cnt_q <= cnt_q + 1'b1;
        end
    end

    assign sec_err = sec_q;
    assign npp_err = npp_q;

    AST_LOAD_LIMIT: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= NW'(MAX_LOADS));                                     // R9
    AST_NPP_STICKY: assert property (@(posedge clk) disable iff (rst)
        npp_q && !page_open |=> npp_q);                               // R9
    AST_UNPAIRED_FLAG: assert property (@(posedge clk) disable iff (rst)
        cfm && !page_open && unpaired |=> sec_q);                     // R10
    AST_OPEN_CLEARS: assert property (@(posedge clk) disable iff (rst)
        page_open |=> !sec_q && !npp_q && cnt_q == '0);               // R11

endmodule

// File: rtl/pr_page_reg.sv
module pr_page_reg
    import pr_pkg::*;
#(
    parameter int SEC_MAIN  = 64,
    parameter int SEC_SPARE = 2,
    parameter int NSEC      = 8,
    parameter int MAX_LOADS = 4,
    localparam int PAGE     = (SEC_MAIN + SEC_SPARE) * NSEC,
    localparam int CW       = $clog2(PAGE + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          busy_i,
    input  logic          rd_i,
    input  logic          wr_i,
    input  logic          col_ld_i,
    input  logic          pgm_cfm_i,
    input  logic          page_open_i,
    input  logic [7:0]    din_i,
    output logic [7:0]    dout_o,
    output logic [CW-1:0] col_o,
    output logic          col_err_o,
    output logic          sec_err_o,
    output logic          npp_err_o
);
    strobe_t       stb;
    logic [CW-1:0] col;

    assign stb.rd = rd_i && !busy_i;
    assign stb.wr = wr_i && !busy_i;

    pr_col_ctr #(.PAGE(PAGE), .CW(CW)) u_col (
        .clk       (clk),
        .rst       (rst),
        .page_open (page_open_i),
        .col_ld    (col_ld_i),
        .din       (din_i),
        .adv       (stb.rd || stb.wr),
        .col       (col),
        .col_err   (col_err_o)
    );

    pr_store #(.PAGE(PAGE), .CW(CW)) u_store (
        .clk  (clk),
        .rst  (rst),
        .stb  (stb),
        .col  (col),
        .din  (din_i),
        .dout (dout_o)
    );

    pr_pgm_track #(
        .SEC_MAIN  (SEC_MAIN),
        .SEC_SPARE (SEC_SPARE),
        .NSEC      (NSEC),
        .MAX_LOADS (MAX_LOADS),
        .CW        (CW)
    ) u_track (
        .clk       (clk),
        .rst       (rst),
        .page_open (page_open_i),
        .we        (stb.wr),
        .col       (col),
        .cfm       (pgm_cfm_i),
        .sec_err   (sec_err_o),
        .npp_err   (npp_err_o)
    );

    assign col_o = col;

    AST_BUSY_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
        busy_i && !col_ld_i && !page_open_i |=> $stable(col_o));     // R8

endmodule

// File: tb/pr_page_reg_test.sv
module pr_page_reg_test;
    localparam int LAST = 527;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        busy_i = 1'b0, rd_i = 1'b0, wr_i = 1'b0, col_ld_i = 1'b0;
    logic        pgm_cfm_i = 1'b0, page_open_i = 1'b0;
    logic [7:0]  din_i = '0;
    logic [7:0]  dout_o;
    logic [9:0]  col_o;
    logic        col_err_o, sec_err_o, npp_err_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pr_page_reg uut (
        .clk(clk), .rst(rst), .busy_i(busy_i), .rd_i(rd_i), .wr_i(wr_i),
        .col_ld_i(col_ld_i), .pgm_cfm_i(pgm_cfm_i), .page_open_i(page_open_i),
        .din_i(din_i), .dout_o(dout_o), .col_o(col_o), .col_err_o(col_err_o),
        .sec_err_o(sec_err_o), .npp_err_o(npp_err_o)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic load_col(input int c);
        @(negedge clk); col_ld_i = 1'b1; din_i = 8'(c);
        @(negedge clk); din_i = 8'(c >> 8);
        @(negedge clk); col_ld_i = 1'b0; din_i = '0;
    endtask

    task automatic wr_byte(input logic [7:0] b);
        wr_i = 1'b1; din_i = b;
        @(negedge clk); wr_i = 1'b0; din_i = '0;
    endtask

    task automatic rd_byte(output int b);
        rd_i = 1'b1;
        @(negedge clk); rd_i = 1'b0; b = int'(dout_o);
    endtask

    task automatic open_page();
        page_open_i = 1'b1;
        @(negedge clk); page_open_i = 1'b0;
    endtask

    task automatic confirm();
        pgm_cfm_i = 1'b1;
        @(negedge clk); pgm_cfm_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 col", int'(col_o), 0);
        chk("R1 dout", int'(dout_o), 0);
        chk("R1 flags", int'({col_err_o, sec_err_o, npp_err_o}), 0);
    endtask

    task automatic t_load_rw();
        int b;
        open_page();
        load_col(100);
        chk("R2 loaded col", int'(col_o), 100);
        wr_byte(8'hA0); wr_byte(8'hA1); wr_byte(8'hA2);
        chk("R4 col after writes", int'(col_o), 103);
        load_col(100);
        rd_byte(b); chk("R3 byte0", b, 'hA0);
        rd_byte(b); chk("R3 byte1", b, 'hA1);
        rd_byte(b); chk("R3 byte2", b, 'hA2);
        chk("R3 col after reads", int'(col_o), 103);
    endtask

    task automatic t_relocate();
        int b;
        load_col(300); wr_byte(8'h55);
        load_col(5);   wr_byte(8'h66);
        load_col(300); rd_byte(b); chk("R5 back to 300", b, 'h55);
        load_col(5);   rd_byte(b); chk("R5 back to 5", b, 'h66);
        load_col(101); rd_byte(b); chk("R5 old data kept", b, 'hA1);
    endtask

    task automatic t_clamp();
        load_col(600);
        chk("R6 clamp col", int'(col_o), LAST);
        chk("R6 err set", int'(col_err_o), 1);
        load_col(200);
        chk("R6 err cleared", int'(col_err_o), 0);
        chk("R6 in-range col", int'(col_o), 200);
        load_col(528);
        chk("R6 first parity column clamps", int'(col_o), LAST);
        chk("R6 err on 528", int'(col_err_o), 1);
    endtask

    task automatic t_saturate();
        int b;
        load_col(526);
        wr_byte(8'h11); wr_byte(8'h22);
        chk("R7 col at last after writes", int'(col_o), LAST);
        load_col(526);
        rd_byte(b); chk("R7 byte 526", b, 'h11);
        rd_byte(b); chk("R7 byte 527", b, 'h22);
        rd_byte(b); chk("R7 repeat last", b, 'h22);
        chk("R7 no wrap", int'(col_o), LAST);
    endtask

    task automatic t_busy();
        int b;
        load_col(10); wr_byte(8'h77);
        load_col(10);
        busy_i = 1'b1;
        wr_byte(8'h99);
        chk("R8 col held on write", int'(col_o), 10);
        rd_byte(b);
        chk("R8 dout held", b, 'h22);
        chk("R8 col held on read", int'(col_o), 10);
        busy_i = 1'b0;
        rd_byte(b);
        chk("R8 no byte stored", b, 'h77);
    endtask

    task automatic t_sector();
        open_page();
        chk("R11 col reset", int'(col_o), 0);
        for (int i = 0; i < 64; i++) wr_byte(8'(i));
        load_col(512); wr_byte(8'hE0); wr_byte(8'hE1);
        confirm();
        chk("R10 paired sector ok", int'(sec_err_o), 0);
        load_col(520); wr_byte(8'h33);
        confirm();
        chk("R10 spare-only flagged", int'(sec_err_o), 1);
        confirm();
        chk("R10 flag sticky", int'(sec_err_o), 1);
        open_page();
        chk("R11 sec flag cleared", int'(sec_err_o), 0);
        load_col(64); wr_byte(8'h44);
        confirm();
        chk("R10 main-only flagged", int'(sec_err_o), 1);
        open_page();
    endtask

    task automatic t_loads();
        for (int i = 0; i < 4; i++) confirm();
        chk("R9 four loads ok", int'(npp_err_o), 0);
        confirm();
        chk("R9 fifth flagged", int'(npp_err_o), 1);
        repeat (3) @(negedge clk);
        chk("R9 sticky", int'(npp_err_o), 1);
        open_page();
        chk("R11 count cleared", int'(npp_err_o), 0);
        confirm();
        chk("R11 fresh count", int'(npp_err_o), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_load_rw();
        t_relocate();
        t_clamp();
        t_saturate();
        t_busy();
        t_sector();
        t_loads();
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule